// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits between a network receive path and the host interrupt line. Each completed frame arrives as a one-cycle event with its status flags, byte length and buffer offset. When the stream is quiet, every good frame raises its own receive-OK interrupt. When good frames arrive close together, they are gathered into a DMA batch that ends with one batch interrupt. The block then publishes three values for that batch: the buffer offset of its first frame, the number of frames and the total byte count.

A good frame is one that passed address filtering, has a legal length and carries a valid CRC. Coalescing needs a legal combination of configuration bits. With coalescing active, the interrupt for the first good frame is withheld until the block knows whether a second frame follows inside the spacing window. The lower and upper spacing bounds are parameters in clock cycles. The gap is the number of cycles from one frame event to the next. A batch holds at most `MAX_FRAMES` frames.

The host clears the batch status flag with a read strobe. The reset input is asynchronous and active-low. Its release is synchronized inside the block, which adds two cycles.

Top module: `rx_coalesce`

## Requirements
- R1: Coalescing is active only when the stream enable, accept-good and good-interrupt enable bits are all set, at least one of the two DMA-mode bits is set, and both early-interrupt enables are clear. Otherwise each good frame in the idle state gives a one-cycle `rx_ok_irq` one cycle after its event, provided the good-interrupt enable is set.
- R2: A frame that fails the address, length or CRC check never produces `rx_ok_irq` and is never counted in a batch.
- R3: With coalescing active, an idle good frame produces no immediate interrupt. If no further frame arrives, its `rx_ok_irq` is raised exactly `GAP_MAX` cycles after its event, and no batch occurs.
- R4: A good frame arriving at a gap between `GAP_MIN` and `GAP_MAX` inclusive after a held frame opens a batch. `dma_mode` stays high while the batch is open.
- R5: When a batch reaches `MAX_FRAMES` frames, it closes. Closing loads `dma_frames`, `dma_bytes` and `dma_sof`, sets `dma_flag`, and gives a one-cycle `dma_irq` one cycle after the last frame event.
- R6: After a full batch closes, the next good frame arriving within the spacing window opens a new batch at once, counting that frame as its first.
- R7: An open batch also closes early in three cases. The first is a failing frame. The second is a gap of more than `GAP_MAX` cycles; in that case `dma_irq` is raised exactly `GAP_MAX` cycles after the last event. The third is a good frame arriving below `GAP_MIN`, which also gets its own `rx_ok_irq` in the same cycle as `dma_irq`. In every early close, the published counts cover only the frames already taken.
- R8: A good frame arriving below `GAP_MIN` after a held frame releases the held interrupt as `rx_ok_irq` and becomes the new held frame.
- R9: `dma_flag` clears one cycle after a one-cycle `evt_rd` strobe. A batch close in the same cycle keeps it set.
- R10: `dma_sof` holds the buffer offset of the first frame in the batch. `dma_bytes` is the sum of the lengths of all frames in the batch.
- R11: After reset, every output is zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stream_en | input | 1 | Coalescing enable |
| cfg_auto_dma | input | 1 | Automatic receive DMA mode bit |
| cfg_dma_only | input | 1 | DMA-only receive mode bit |
| cfg_accept_good | input | 1 | Accept good frames |
| cfg_good_irq_en | input | 1 | Good-frame interrupt enable |
| cfg_early_dest_irq_en | input | 1 | Early destination-match interrupt enable |
| cfg_early_128_irq_en | input | 1 | Early interrupt after 128 bytes enable |
| frame_done | input | 1 | One-cycle frame completion event |
| frame_addr_ok | input | 1 | Frame passed the address filter |
| frame_len_ok | input | 1 | Frame length is legal |
| frame_crc_ok | input | 1 | Frame CRC is valid |
| frame_len | input | LEN_W | Frame byte length |
| frame_ofs | input | OFS_W | Frame buffer offset |
| evt_rd | input | 1 | Host read strobe of the event status |
| rx_ok_irq | output | 1 | Per-frame receive-OK interrupt pulse |
| dma_mode | output | 1 | Receive DMA mode request, high during a batch |
| dma_irq | output | 1 | Batch-complete interrupt pulse |
| dma_flag | output | 1 | Batch-complete status bit |
| dma_sof | output | OFS_W | Offset of the first frame in the last batch |
| dma_frames | output | FRM_W | Frame count of the last batch |
| dma_bytes | output | BYTE_W | Byte count of the last batch |

## Verification
The hardest situations to reach are the timed ones. These are a held frame or an open batch running out exactly at the upper gap bound, and a full batch followed directly by another frame inside the window. The bench uses small gap bounds and places every frame event at an exact cycle distance from the previous one. A vector table builds a full eight-frame batch, a chained one-frame batch ended by a failing frame, and an early frame both in the held state and inside a batch. Directed tests then sample one cycle before and exactly at the timeout.

// File: rtl/rx_coalesce_pkg.sv
package rx_coalesce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_BATCH = 2'd2,
    ST_CHAIN = 2'd3
  } coal_state_t;
endpackage

// File: rtl/rx_gap_timer.sv
module rx_gap_timer #(
  parameter int GAP_MIN = 960,
  parameter int GAP_MAX = 5200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  output logic in_window,
  output logic expire
);
  localparam int CNT_W = $clog2(GAP_MAX + 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // restart at each frame event, saturate one past the upper bound
  always_comb begin
    cnt_en = frame_done || (cnt_q <= CNT_W'(GAP_MAX));
    cnt_d  = frame_done ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(GAP_MAX + 1);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign in_window = (cnt_q >= CNT_W'(GAP_MIN)) && (cnt_q <= CNT_W'(GAP_MAX));
  assign expire    = (cnt_q == CNT_W'(GAP_MAX)) && !frame_done;
endmodule

// File: rtl/rx_batch_accum.sv
module rx_batch_accum #(
  parameter int LEN_W  = 12,
  parameter int OFS_W  = 16,
  parameter int FRM_W  = 4,
  parameter int BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              add,
  input  logic [LEN_W-1:0]  len,
  input  logic [OFS_W-1:0]  ofs,
  output logic [FRM_W-1:0]  cnt_q,
  output logic [FRM_W-1:0]  cnt_nxt,
  output logic [BYTE_W-1:0] bytes_nxt,
  output logic [OFS_W-1:0]  sof_nxt
);
  logic [BYTE_W-1:0] bytes_q;
  logic [OFS_W-1:0]  sof_q;
  logic [BYTE_W-1:0] len_ext;
  logic              acc_en;

  assign len_ext = {{(BYTE_W-LEN_W){1'b0}}, len};
  assign acc_en  = load || add;

  always_comb begin
    cnt_nxt   = cnt_q;
    bytes_nxt = bytes_q;
    sof_nxt   = sof_q;
    if (load) begin
      cnt_nxt   = FRM_W'(1);
      bytes_nxt = len_ext;
      sof_nxt   = ofs;
    end else if (add) begin
      cnt_nxt   = cnt_q + FRM_W'(1);
      bytes_nxt = bytes_q + len_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bytes_q <= '0;
      sof_q   <= '0;
    end else if (acc_en) begin
      cnt_q   <= cnt_nxt;
      bytes_q <= bytes_nxt;
      sof_q   <= sof_nxt;
    end
  end
endmodule

// File: rtl/rx_batch_pub.sv
module rx_batch_pub #(
  parameter int OFS_W  = 16,
  parameter int FRM_W  = 4,
  parameter int BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic              evt_rd,
  input  logic [OFS_W-1:0]  sof_in,
  input  logic [FRM_W-1:0]  cnt_in,
  input  logic [BYTE_W-1:0] bytes_in,
  output logic [OFS_W-1:0]  sof_q,
  output logic [FRM_W-1:0]  cnt_q,
  output logic [BYTE_W-1:0] bytes_q,
  output logic              flag_q,
  output logic              irq_q
);
  logic flag_en, flag_d;

  assign flag_en = close || evt_rd;
  assign flag_d  = close;   // a close wins over a clearing read

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_q   <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else if (close) begin
      sof_q   <= sof_in;
      cnt_q   <= cnt_in;
      bytes_q <= bytes_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= close;
  end
endmodule

// File: rtl/rx_coalesce.sv
module rx_coalesce
  import rx_coalesce_pkg::*;
#(
  parameter int GAP_MIN    = 960,
  parameter int GAP_MAX    = 5200,
  parameter int MAX_FRAMES = 8,
  parameter int LEN_W      = 12,
  parameter int OFS_W      = 16,
  parameter int FRM_W      = $clog2(MAX_FRAMES + 1),
  parameter int BYTE_W     = LEN_W + FRM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stream_en,
  input  logic              cfg_auto_dma,
  input  logic              cfg_dma_only,
  input  logic              cfg_accept_good,
  input  logic              cfg_good_irq_en,
  input  logic              cfg_early_dest_irq_en,
  input  logic              cfg_early_128_irq_en,
  input  logic              frame_done,
  input  logic              frame_addr_ok,
  input  logic              frame_len_ok,
  input  logic              frame_crc_ok,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [OFS_W-1:0]  frame_ofs,
  input  logic              evt_rd,
  output logic              rx_ok_irq,
  output logic              dma_mode,
  output logic              dma_irq,
  output logic              dma_flag,
  output logic [OFS_W-1:0]  dma_sof,
  output logic [FRM_W-1:0]  dma_frames,
  output logic [BYTE_W-1:0] dma_bytes
);
  localparam logic [FRM_W-1:0] LAST_SLOT = FRM_W'(MAX_FRAMES - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  coal_state_t state, state_d;
  logic coal_ok, good_frm, bad_frm, b2b, in_window, expire;
  logic load, add, close, rx_set;
  logic [FRM_W-1:0]  acc_cnt, acc_cnt_nxt;
  logic [BYTE_W-1:0] acc_bytes_nxt;
  logic [OFS_W-1:0]  acc_sof_nxt;

  assign coal_ok = cfg_stream_en && (cfg_auto_dma || cfg_dma_only) &&
                   cfg_accept_good && cfg_good_irq_en &&
                   !cfg_early_dest_irq_en && !cfg_early_128_irq_en;
  assign good_frm = frame_done && frame_addr_ok && frame_len_ok && frame_crc_ok;
  assign bad_frm  = frame_done && !good_frm;
  assign b2b      = good_frm && in_window;

  rx_gap_timer #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_gap (
    .clk(clk), .rst_n(rst_sync), .frame_done(frame_done),
    .in_window(in_window), .expire(expire)
  );

  rx_batch_accum #(.LEN_W(LEN_W), .OFS_W(OFS_W), .FRM_W(FRM_W), .BYTE_W(BYTE_W)) u_acc (
    .clk(clk), .rst_n(rst_sync), .load(load), .add(add),
    .len(frame_len), .ofs(frame_ofs), .cnt_q(acc_cnt), .cnt_nxt(acc_cnt_nxt),
    .bytes_nxt(acc_bytes_nxt), .sof_nxt(acc_sof_nxt)
  );

  rx_batch_pub #(.OFS_W(OFS_W), .FRM_W(FRM_W), .BYTE_W(BYTE_W)) u_pub (
    .clk(clk), .rst_n(rst_sync), .close(close), .evt_rd(evt_rd),
    .sof_in(acc_sof_nxt), .cnt_in(acc_cnt_nxt), .bytes_in(acc_bytes_nxt),
    .sof_q(dma_sof), .cnt_q(dma_frames), .bytes_q(dma_bytes),
    .flag_q(dma_flag), .irq_q(dma_irq)
  );

  always_comb begin
    state_d = state;
    load    = 1'b0;
    add     = 1'b0;
    close   = 1'b0;
    rx_set  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (good_frm) begin
          if (coal_ok) begin
            state_d = ST_HOLD;
            load    = 1'b1;
          end else begin
            rx_set  = cfg_good_irq_en;
          end
        end
      end
      ST_HOLD: begin
        if (b2b) begin
          state_d = ST_BATCH;
          add     = 1'b1;
        end else if (good_frm) begin
          rx_set  = 1'b1;          // early: release held, hold the new one
          load    = 1'b1;
        end else if (bad_frm || expire) begin
          rx_set  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_BATCH: begin
        if (b2b) begin
          add = 1'b1;
          if (acc_cnt == LAST_SLOT) begin
            close   = 1'b1;
            state_d = ST_CHAIN;
          end
        end else if (good_frm) begin
          close   = 1'b1;
          rx_set  = 1'b1;
          state_d = ST_IDLE;
        end else if (bad_frm || expire) begin
          close   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_CHAIN: begin
        if (good_frm) begin
          state_d = b2b ? ST_BATCH : ST_HOLD;
          load    = 1'b1;
        end else if (bad_frm || expire) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) state <= ST_IDLE;
    else           state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) rx_ok_irq <= 1'b0;
    else           rx_ok_irq <= rx_set;
  end

  assign dma_mode = (state == ST_BATCH);
endmodule

// File: rtl/rx_coalesce_chk.sv
module rx_coalesce_chk #(
  parameter int MAX_FRAMES = 8,
  parameter int FRM_W      = 4
) (
  input logic             clk,
  input logic             rst_sync,
  input logic [1:0]       state,
  input logic             coal_ok,
  input logic             frame_done,
  input logic             frame_addr_ok,
  input logic             frame_len_ok,
  input logic             frame_crc_ok,
  input logic             cfg_good_irq_en,
  input logic             evt_rd,
  input logic             rx_ok_irq,
  input logic             dma_mode,
  input logic             dma_irq,
  input logic             dma_flag,
  input logic [FRM_W-1:0] dma_frames
);
  logic frm_good;
  assign frm_good = frame_addr_ok && frame_len_ok && frame_crc_ok;

  // R1: per-frame interrupt when coalescing is off
  p_direct_irq_r1: assert property (@(posedge clk) disable iff (!rst_sync)
    (state == 2'd0 && frame_done && frm_good && !coal_ok && cfg_good_irq_en) |=> rx_ok_irq);

  // R2: a failing frame seen while idle raises nothing
  p_bad_silent_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    (state == 2'd0 && frame_done && !frm_good) |=> !rx_ok_irq);

  // R4: a batch interrupt only follows a cycle in DMA mode
  p_close_from_dma_r4: assert property (@(posedge clk) disable iff (!rst_sync)
    dma_irq |-> $past(dma_mode));

  // R5: close sets the status bit and reports a legal count
  p_close_flag_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    dma_irq |-> (dma_flag && dma_frames >= FRM_W'(1) && dma_frames <= FRM_W'(MAX_FRAMES)));

  // R5: the batch interrupt lasts one cycle
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    dma_irq |=> !dma_irq);

  // R9: read clears the flag unless a close lands together
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (evt_rd && !dma_mode) |=> !dma_flag);
endmodule

bind rx_coalesce rx_coalesce_chk #(.MAX_FRAMES(MAX_FRAMES), .FRM_W(FRM_W)) u_chk (
  .clk(clk), .rst_sync(rst_sync), .state(state), .coal_ok(coal_ok),
  .frame_done(frame_done), .frame_addr_ok(frame_addr_ok), .frame_len_ok(frame_len_ok),
  .frame_crc_ok(frame_crc_ok), .cfg_good_irq_en(cfg_good_irq_en), .evt_rd(evt_rd),
  .rx_ok_irq(rx_ok_irq), .dma_mode(dma_mode), .dma_irq(dma_irq),
  .dma_flag(dma_flag), .dma_frames(dma_frames)
);

// File: tb/rx_coalesce_bench.sv
module rx_coalesce_bench;
  localparam int GMIN = 4;
  localparam int GMAX = 20;
  localparam int MAXF = 8;
  localparam int LW = 12, OW = 16, FW = 4, BW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic c_stream, c_auto, c_only, c_acc, c_gie, c_edest, c_e128;
  logic f_done, f_addr, f_len_ok, f_crc;
  logic [LW-1:0] f_len;
  logic [OW-1:0] f_ofs;
  logic evt_rd;
  logic rx_ok_irq, dma_mode, dma_irq, dma_flag;
  logic [OW-1:0] dma_sof;
  logic [FW-1:0] dma_frames;
  logic [BW-1:0] dma_bytes;

  rx_coalesce #(.GAP_MIN(GMIN), .GAP_MAX(GMAX), .MAX_FRAMES(MAXF),
                .LEN_W(LW), .OFS_W(OW)) u_rx_coalesce (
    .clk(clk), .rst_n(rst_n),
    .cfg_stream_en(c_stream), .cfg_auto_dma(c_auto), .cfg_dma_only(c_only),
    .cfg_accept_good(c_acc), .cfg_good_irq_en(c_gie),
    .cfg_early_dest_irq_en(c_edest), .cfg_early_128_irq_en(c_e128),
    .frame_done(f_done), .frame_addr_ok(f_addr), .frame_len_ok(f_len_ok),
    .frame_crc_ok(f_crc), .frame_len(f_len), .frame_ofs(f_ofs), .evt_rd(evt_rd),
    .rx_ok_irq(rx_ok_irq), .dma_mode(dma_mode), .dma_irq(dma_irq),
    .dma_flag(dma_flag), .dma_sof(dma_sof), .dma_frames(dma_frames),
    .dma_bytes(dma_bytes)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one frame event at the current negedge; returns one negedge later
  task automatic frame(input bit good, input int len, input int ofs);
    f_done   = 1'b1;
    f_addr   = good;
    f_len_ok = 1'b1;
    f_crc    = 1'b1;
    f_len    = LW'(len);
    f_ofs    = OW'(ofs);
    @(negedge clk);
    f_done   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_legal();
    c_stream = 1; c_auto = 1; c_only = 0; c_acc = 1; c_gie = 1; c_edest = 0; c_e128 = 0;
  endtask

  // idle cycles before the event, good, expected rx, expected dma, frames, bytes
  typedef struct packed {
    logic [7:0]  pre;
    logic        good;
    logic        exp_rx;
    logic        exp_dma;
    logic [3:0]  frames;
    logic [15:0] bytes;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{8'd0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},    // held first frame (R3)
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},    // gap 10 opens batch (R4)
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},
    '{8'd9, 1'b1, 1'b0, 1'b1, 4'd8, 16'd512},  // eighth frame closes (R5)
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},    // chained batch (R6)
    '{8'd9, 1'b0, 1'b0, 1'b1, 4'd1, 16'd64},   // failing frame closes (R7, R2)
    '{8'd1, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},    // idle good frame held
    '{8'd1, 1'b1, 1'b1, 1'b0, 4'd0, 16'd0},    // early in hold (R8)
    '{8'd9, 1'b1, 1'b0, 1'b0, 4'd0, 16'd0},    // batch of two opens
    '{8'd1, 1'b1, 1'b1, 1'b1, 4'd2, 16'd128}   // early good closes (R7)
  };

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_rd = 0; f_done = 0; f_addr = 0; f_len_ok = 0; f_crc = 0;
    f_len = '0; f_ofs = '0;
    cfg_legal();
    idle(3);
    rst_n = 1;
    idle(4);

    // R11: reset state
    chk("R11 rx_ok_irq", 32'(rx_ok_irq), 0);
    chk("R11 dma_mode", 32'(dma_mode), 0);
    chk("R11 dma_irq", 32'(dma_irq), 0);
    chk("R11 dma_flag", 32'(dma_flag), 0);
    chk("R11 counts", 32'({dma_sof, dma_frames, dma_bytes}), 0);

    // vector walk
    for (int i = 0; i < 14; i++) begin
      idle(int'(TBL[i].pre));
      frame(TBL[i].good, 64, 16 * i);
      chk($sformatf("R3/R8 rx vec%0d", i), 32'(rx_ok_irq), 32'(TBL[i].exp_rx));
      chk($sformatf("R5/R7 dma vec%0d", i), 32'(dma_irq), 32'(TBL[i].exp_dma));
      if (TBL[i].exp_dma) begin
        chk($sformatf("R5/R6 frames vec%0d", i), 32'(dma_frames), 32'(TBL[i].frames));
        chk($sformatf("R10 bytes vec%0d", i), 32'(dma_bytes), 32'(TBL[i].bytes));
      end
    end

    // R3: held frame released exactly GAP_MAX cycles later
    idle(3);
    frame(1'b1, 50, 0);
    idle(GMAX - 1);
    chk("R3 rx before timeout", 32'(rx_ok_irq), 0);
    idle(1);
    chk("R3 rx at timeout", 32'(rx_ok_irq), 1);
    chk("R3 no batch", 32'(dma_irq), 0);

    // R4 + R7 + R10: batch of two closed by timeout
    idle(3);
    frame(1'b1, 10, 16'h40);
    idle(GMIN - 1);
    frame(1'b1, 20, 16'h80);
    chk("R4 dma_mode in batch", 32'(dma_mode), 1);
    idle(GMAX - 1);
    chk("R7 no close before timeout", 32'(dma_irq), 0);
    idle(1);
    chk("R7 close at timeout", 32'(dma_irq), 1);
    chk("R7 frames", 32'(dma_frames), 2);
    chk("R10 sof", 32'(dma_sof), 32'h40);
    chk("R10 bytes", 32'(dma_bytes), 30);
    chk("R4 dma_mode released", 32'(dma_mode), 0);

    // R9: read clears the flag
    chk("R9 flag set", 32'(dma_flag), 1);
    evt_rd = 1; idle(1); evt_rd = 0;
    chk("R9 flag cleared", 32'(dma_flag), 0);

    // R2: failing frame in idle is silent
    idle(2);
    frame(1'b0, 30, 0);
    chk("R2 no rx", 32'(rx_ok_irq), 0);
    idle(GMAX + 2);
    chk("R2 no late rx", 32'(rx_ok_irq), 0);
    chk("R2 no batch", 32'(dma_flag), 0);

    // R1: stream enable without any DMA bit is ignored
    c_auto = 0; c_only = 0;
    frame(1'b1, 30, 0);
    chk("R1 no DMA bit: immediate rx", 32'(rx_ok_irq), 1);
    idle(GMIN - 1);
    frame(1'b1, 30, 0);
    chk("R1 no DMA bit: second rx", 32'(rx_ok_irq), 1);
    chk("R1 no DMA bit: no dma_mode", 32'(dma_mode), 0);

    // R1: early 128-byte interrupt enabled forces per-frame mode
    idle(GMAX + 2);
    c_only = 1; c_e128 = 1;
    frame(1'b1, 30, 0);
    chk("R1 early irq enabled: immediate rx", 32'(rx_ok_irq), 1);

    // R1: DMA-only bit alone permits coalescing
    idle(GMAX + 2);
    c_e128 = 0;
    frame(1'b1, 30, 0);
    chk("R1 DMA-only: frame held", 32'(rx_ok_irq), 0);
    idle(GMAX);
    chk("R1 DMA-only: released", 32'(rx_ok_irq), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule